// File: doc/BRIEF.md
# Parallel Printer Output Controller

This block connects a processor bus to a character printer over an 8-bit parallel link. The processor deposits one character in a buffer register. It then clears the ready flag in a status register. The controller waits until the printer reports that it is ready, puts the character on the parallel data lines and emits a one-cycle transfer-request strobe. When the printer drops its ready line to show it has taken the character, the controller raises the ready flag again.

Software may run the block in either of two ways. In interrupt mode the interrupt-enable bit of the status register is set, and an active-low interrupt line signals each time the controller can accept a character. In polled mode that bit is clear, the interrupt line stays high, and software reads the status register until the ready flag returns. The bidirectional processor bus is split into separate write-data and read-data buses. The printer ready input passes through a configurable synchronizer before the controller uses it.

Top module: `prn_out_port`

## Requirements
- R1: After a synchronous reset the status register reads 8'h81 (ready = bit 7, interrupt enable = bit 0), irq_n is 0, prn_strobe is 0, and prn_data and bus_rdata are 0.
- R2: irq_n is 0 exactly when status bit 7 and status bit 0 are both 1. It changes on the same clock edge as the status register.
- R3: While status bit 0 is 0, irq_n stays 1, and software can observe bit 7 through status reads.
- R4: A write takes effect only when bus_cs = 1 and bus_wr = 1. bus_sel = 1 selects the buffer register and bus_sel = 0 selects the status register. With bus_cs = 0, neither register changes.
- R5: A read (bus_cs = 1, bus_wr = 0) loads bus_rdata with the status register (bus_sel = 0) or the buffer register (bus_sel = 1) on the edge that samples the access. At all other times bus_rdata holds its value.
- R6: A status write stores data bits 6..0 as written. Data bit 7 = 0 clears the ready flag. Data bit 7 = 1 leaves the ready flag unchanged.
- R7: When the controller is idle, the ready flag is 0 and the synchronized printer ready is 1, prn_data is loaded from the buffer and prn_strobe is 1 for exactly one cycle.
- R8: While the synchronized printer ready is 0, no strobe is issued, even if a character is pending.
- R9: prn_data stays stable from the strobe until the controller sees the synchronized ready low. Buffer writes during this time do not alter prn_data.
- R10: On the edge at which the controller, after a strobe, samples the synchronized ready as 0, the ready flag is set to 1. This re-asserts irq_n when interrupts are enabled.
- R11: prn_ready passes through SYNC_STAGES flip-flops (0 means direct). A strobe therefore appears SYNC_STAGES + 1 edges after prn_ready rises.
- R12: A reset during a transfer returns the handshake to idle and the status register to 8'h81, and no further strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select, qualifies every access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 1 = buffer register, 0 = status register |
| bus_wdata | input | DATA_W | Write data from processor |
| bus_rdata | output | DATA_W | Registered read data to processor |
| irq_n | output | 1 | Active-low interrupt request |
| prn_data | output | DATA_W | Parallel character to printer |
| prn_strobe | output | 1 | One-cycle transfer request |
| prn_ready | input | 1 | Printer ready (1 = can take a character) |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a two-stage ready synchronizer. With two stages, the printer model's ready edges reach the controller several cycles late. This opens the windows in which software rewrites the status register, or writes a new buffer value, while a character is still in flight. The bench also measures the synchronizer latency exactly, from a ready rise to the strobe, and places a reset inside a transfer that the printer model is still completing.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_HOLD = 1'b1
  } xfer_st_e;
endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 0) begin : g_direct
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else if (STAGES == 1) chain_q <= din;
        else chain_q <= {chain_q[STAGES-2:0], din};
      end
      assign dout = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/prn_regs.sv
module prn_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_cs,
  input  logic              acc_wr,
  input  logic              acc_sel,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              xfer_done,
  output logic [DATA_W-1:0] acc_rdata,
  output logic [DATA_W-1:0] buf_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq_n
);
  localparam int RDY_BIT = DATA_W - 1;
  localparam int IEN_BIT = 0;
  localparam logic [DATA_W-1:0] STAT_RST = {1'b1, {(DATA_W-2){1'b0}}, 1'b1};

  logic              wr_buf, wr_stat, rd_any;
  logic [DATA_W-1:0] stat_nx;

  assign wr_buf  = acc_cs & acc_wr & acc_sel;
  assign wr_stat = acc_cs & acc_wr & ~acc_sel;
  assign rd_any  = acc_cs & ~acc_wr;

  always_comb begin
    stat_nx = stat_q;
    if (wr_stat) begin
      stat_nx[RDY_BIT-1:0] = acc_wdata[RDY_BIT-1:0];
      if (!acc_wdata[RDY_BIT]) stat_nx[RDY_BIT] = 1'b0;
    end
    if (xfer_done) stat_nx[RDY_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= STAT_RST;
      buf_q     <= '0;
      acc_rdata <= '0;
      irq_n     <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      irq_n  <= ~(stat_nx[RDY_BIT] & stat_nx[IEN_BIT]);
      if (wr_buf) buf_q <= acc_wdata;
      if (rd_any) acc_rdata <= acc_sel ? buf_q : stat_q;
    end
  end
endmodule

// File: rtl/prn_xfer.sv
module prn_xfer
  import prn_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              rdy_s,
  input  logic [DATA_W-1:0] buf_q,
  output logic [DATA_W-1:0] pd_q,
  output logic              strobe_q,
  output logic              done,
  output logic              busy
);
  xfer_st_e st_q;
  logic     start;

  assign start = (st_q == XS_IDLE) & req & rdy_s;
  assign done  = (st_q == XS_HOLD) & ~rdy_s & ~strobe_q;
  assign busy  = (st_q == XS_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= XS_IDLE;
      pd_q     <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= start;
      if (start) begin
        pd_q <= buf_q;
        st_q <= XS_HOLD;
      end else if (done) begin
        st_q <= XS_IDLE;
      end
    end
  end
endmodule

// File: rtl/prn_out_port.sv
module prn_out_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe,
  input  logic              prn_ready
);
  localparam int RDY_BIT = DATA_W - 1;

  logic              rdy_s, xfer_done, xfer_busy;
  logic [DATA_W-1:0] buf_q, stat_q;

  prn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(prn_ready), .dout(rdy_s)
  );

  prn_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .acc_cs(bus_cs), .acc_wr(bus_wr), .acc_sel(bus_sel), .acc_wdata(bus_wdata),
    .xfer_done(xfer_done), .acc_rdata(bus_rdata),
    .buf_q(buf_q), .stat_q(stat_q), .irq_n(irq_n)
  );

  prn_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst(rst), .req(~stat_q[RDY_BIT]), .rdy_s(rdy_s),
    .buf_q(buf_q), .pd_q(prn_data), .strobe_q(prn_strobe),
    .done(xfer_done), .busy(xfer_busy)
  );
endmodule

// File: rtl/prn_out_port_chk.sv
module prn_out_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic              irq_n,
  input logic [DATA_W-1:0] prn_data,
  input logic [DATA_W-1:0] stat_q,
  input logic              rdy_s,
  input logic              busy
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe); // R7
  AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (stat_q[DATA_W-1] && stat_q[0]) |-> !irq_n); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !stat_q[0] |-> irq_n); // R3
  AST_STROBE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(rdy_s)); // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !strobe) |-> $stable(prn_data)); // R9
  AST_FLAG_SET_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[DATA_W-1]) |-> ($past(busy) && !$past(rdy_s))); // R10
endmodule

bind prn_out_port prn_out_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .strobe(prn_strobe), .irq_n(irq_n),
  .prn_data(prn_data), .stat_q(stat_q), .rdy_s(rdy_s), .busy(xfer_busy)
);

// File: tb/test_prn_out_port.sv
`timescale 1ns/1ps
module test_prn_out_port;
  localparam int W = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_cs = 1'b0, bus_wr = 1'b0, bus_sel = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata, prn_data;
  logic irq_n, prn_strobe;
  logic prn_ready = 1'b0;
  logic hold_busy = 1'b0;
  int checks = 0, errors = 0, ncap = 0, pd_moves = 0;
  logic [W-1:0] cap = '0;

  always #2.5 clk = ~clk;

  prn_out_port #(.DATA_W(W), .SYNC_STAGES(SYNC)) i_prn_out_port (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
    .prn_data(prn_data), .prn_strobe(prn_strobe), .prn_ready(prn_ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // printer model: takes a character on strobe, drops ready after 3 cycles
  initial begin
    forever begin
      @(negedge clk); #1;
      if (prn_strobe && prn_ready) begin
        cap = prn_data; ncap++;
        repeat (3) begin @(negedge clk); #1; if (prn_data !== cap) pd_moves++; end
        prn_ready = 1'b0;
        repeat (6) begin @(negedge clk); #1; end
      end else begin
        prn_ready = !hold_busy && !rst;
      end
    end
  end

  task automatic bus_write(input logic sel, input logic [W-1:0] d);
    @(negedge clk); bus_cs = 1; bus_wr = 1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic sel, output logic [W-1:0] d);
    @(negedge clk); bus_cs = 1; bus_wr = 0; bus_sel = sel;
    @(negedge clk); bus_cs = 0; d = bus_rdata;
  endtask

  task automatic wait_strobe(output int seen);
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk); if (prn_strobe) seen = 1;
    end
  endtask

  task automatic wait_irq_low(output int ok);
    ok = 0;
    for (int i = 0; i < 80 && !ok; i++) begin
      @(negedge clk); if (!irq_n) ok = 1;
    end
  endtask

  task automatic t_reset;
    logic [W-1:0] r;
    rst = 1; repeat (4) @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 irq_n", irq_n, 0);
    check("R1 strobe", prn_strobe, 0);
    check("R1 prn_data", prn_data, 0);
    check("R1 rdata", bus_rdata, 0);
    bus_read(0, r);
    check("R1 status reset", r, 8'h81);
  endtask

  task automatic t_regs;
    logic [W-1:0] r;
    bus_write(1, 8'h3C);
    bus_read(1, r);
    check("R4 R5 buffer readback", r, 8'h3C);
    @(negedge clk); bus_cs = 0; bus_wr = 1; bus_sel = 1; bus_wdata = 8'hEE;
    @(negedge clk); bus_sel = 0; bus_wdata = 8'h00;
    @(negedge clk); bus_wr = 0;
    bus_read(1, r);
    check("R4 no buffer write without cs", r, 8'h3C);
    bus_read(0, r);
    check("R4 no status write without cs", r, 8'h81);
    repeat (3) @(negedge clk);
    check("R5 rdata held when idle", bus_rdata, 8'h81);
  endtask

  task automatic t_irq_flow;
    logic [W-1:0] r; int seen, ok, n0;
    n0 = ncap;
    bus_write(1, 8'h5A);
    bus_write(0, 8'h01);
    check("R2 irq_n high once flag cleared", irq_n, 1);
    wait_strobe(seen);
    check("R7 strobe seen", seen, 1);
    check("R7 prn_data at strobe", prn_data, 8'h5A);
    @(negedge clk);
    check("R7 strobe one cycle", prn_strobe, 0);
    bus_cs = 1; bus_wr = 1; bus_sel = 1; bus_wdata = 8'h77;
    @(negedge clk); bus_cs = 0; bus_wr = 0;
    check("R9 prn_data unchanged by buffer write", prn_data, 8'h5A);
    wait_irq_low(ok);
    check("R10 irq re-armed", ok, 1);
    bus_read(0, r);
    check("R10 status ready again", r, 8'h81);
    check("R7 printer captured one char", ncap - n0, 1);
    check("R9 prn_data stable during handshake", pd_moves, 0);
  endtask

  task automatic t_polled;
    logic [W-1:0] r; int done_flag, irq_bad;
    bus_write(0, 8'h80);
    bus_read(0, r);
    check("R3 R6 status after disabling irq", r, 8'h80);
    check("R3 irq_n high", irq_n, 1);
    bus_write(1, 8'hA5);
    bus_write(0, 8'h00);
    done_flag = 0; irq_bad = 0;
    for (int i = 0; i < 40 && !done_flag; i++) begin
      bus_read(0, r);
      if (irq_n !== 1'b1) irq_bad++;
      if (r[7]) done_flag = 1;
    end
    check("R3 polled completion", done_flag, 1);
    check("R3 irq_n stayed high", irq_bad, 0);
    check("R7 polled char", cap, 8'hA5);
  endtask

  task automatic t_bit7_ignored;
    logic [W-1:0] r; int ok;
    bus_write(0, 8'h01);
    bus_write(0, 8'hFF);
    bus_read(0, r);
    check("R6 write of 1 to ready flag ignored", r, 8'h7F);
    wait_irq_low(ok);
    check("R10 completes after ignored write", ok, 1);
    bus_read(0, r);
    check("R6 R10 status after completion", r, 8'hFF);
    bus_write(0, 8'h81);
  endtask

  task automatic t_not_ready;
    logic [W-1:0] r; int strobes, k, seen;
    hold_busy = 1;
    repeat (15) @(negedge clk);
    bus_write(1, 8'hC3);
    bus_write(0, 8'h01);
    strobes = 0;
    repeat (20) begin @(negedge clk); if (prn_strobe) strobes++; end
    check("R8 no strobe while printer busy", strobes, 0);
    bus_read(0, r);
    check("R8 still pending", r, 8'h01);
    @(negedge clk); hold_busy = 0;
    wait (prn_ready === 1'b1);
    k = 0; seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk); k++; if (prn_strobe) seen = 1;
    end
    check("R11 strobe latency after ready", k, SYNC + 1);
    check("R8 char sent after ready", prn_data, 8'hC3);
    wait_irq_low(seen);
  endtask

  task automatic t_reset_mid;
    logic [W-1:0] r; int seen, strobes;
    bus_write(1, 8'h11);
    bus_write(0, 8'h01);
    wait_strobe(seen);
    @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    check("R12 irq_n after reset", irq_n, 0);
    check("R12 strobe after reset", prn_strobe, 0);
    strobes = 0;
    repeat (30) begin @(negedge clk); if (prn_strobe) strobes++; end
    check("R12 no strobe after reset", strobes, 0);
    bus_read(0, r);
    check("R12 status after reset", r, 8'h81);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_irq_flow();
    t_polled();
    t_bit7_ignored();
    t_not_ready();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule